// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block chooses which of five interrupt sources is presented to the processor. The sources are external line 0, timer 0 overflow, external line 1, timer 1 overflow and the serial port. Each cycle it registers the raw request flags. It gates them with a per-source enable and a master enable, then splits the survivors into a low and a high priority group using a priority register. It presents one winner as a valid signal, a level bit and a 16-bit vector address. The processor takes the winner by raising an acknowledge while valid is high.

The controller remembers which levels are being serviced. While a low-level handler runs, only high-level requests are presented. While a high-level handler runs, nothing is presented. A return strobe from the processor ends the innermost active handler. Both configuration registers sit behind one small write/read port, selected by a single bit.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the enable register, the priority register and both in-service bits are 0, and `irq_valid` is 0.
- R2: Enable register (`cfg_sel`=0) fields are: bit 7 master enable, bit 4 serial, bit 3 timer 1, bit 2 external 1, bit 1 timer 0, bit 0 external 0. Bits 6 and 5 always read 0, and writing 1 to them changes nothing in arbitration.
- R3: With the master enable bit at 0, no request is presented, whatever the flags and source enables are.
- R4: With the master enable at 1, a source whose own enable bit is 0 is never presented.
- R5: Request flags are registered once before arbitration. A flag that rises in one cycle is presented after the next clock edge, not in the same cycle.
- R6: Priority register (`cfg_sel`=1) uses the same bit-per-source layout in bits 4..0, with 1 meaning high level. Bits 7..5 read 0.
- R7: Inside one level the winner is the requesting source with the lowest bit index: external 0, then timer 0, external 1, timer 1 and serial.
- R8: Any presented high-level request beats every low-level request, whatever their bit positions. `irq_level` is 1 for a high winner.
- R9: `irq_vector` equals 0x0003 + 8 × (bit index of the winner), giving 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R10: A cycle with `irq_valid` and `irq_ack` both high sets the in-service bit of the winner's level (`active_lvl` bit 0 low, bit 1 high) at that clock edge.
- R11: While the low level is in service, only high-level requests are presented. While the high level is in service, nothing is presented.
- R12: `irq_reti` clears the high in-service bit if it is set, otherwise the low one. When a return and an accepted acknowledge fall in the same cycle, the clear is applied first and the new level is then set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the selected configuration register |
| cfg_sel | input | 1 | 0 selects the enable register, 1 the priority register |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the selected register, combinational |
| src_req | input | 5 | Request flags, bit order external 0, timer 0, external 1, timer 1, serial |
| irq_valid | output | 1 | A request is presented |
| irq_level | output | 1 | Level of the presented request, 1 = high |
| irq_vector | output | 16 | Vector address of the presented request, 0 when idle |
| irq_ack | input | 1 | Processor takes the presented request |
| irq_reti | input | 1 | Return strobe that ends the innermost active handler |
| active_lvl | output | 2 | In-service bits, bit 0 low level, bit 1 high level |

## Verification
Acceptance of a new request and completion of the current handler can fall in the same cycle. The bench provokes this by leaving a low handler in service and raising a high-level request. It then pulses `irq_ack` and `irq_reti` together on the edge where the high vector is shown. The result is judged on `active_lvl`: the return must retire the low level and the acknowledge must mark the high one, leaving only bit 1 set. Preemption while the low level is in service is checked by the same sequence.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

   typedef enum logic {
      LVL_LO = 1'b0,
      LVL_HI = 1'b1
   } irq_lvl_e;

   localparam int unsigned LVL_N = 2;

   // Bit mask with the lowest n bits set, w bits wide (w <= 32).
   function automatic logic [31:0] low_ones(input int unsigned n);
      logic [31:0] m;
      m = '0;
      for (int unsigned i = 0; i < n; i++) m[i] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
   import irq_arb_pkg::*;
#(
   parameter int unsigned REG_W   = 8,
   parameter int unsigned NUM_SRC = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               sel,
   input  logic [REG_W-1:0]   wdata,
   output logic [REG_W-1:0]   rdata,
   output logic [NUM_SRC-1:0] src_en,
   output logic [NUM_SRC-1:0] src_hi,
   output logic               glb_en
);

   localparam logic [REG_W-1:0] SRC_MASK = REG_W'(low_ones(NUM_SRC));
   localparam logic [REG_W-1:0] EN_MASK  = SRC_MASK | (REG_W'(1) << (REG_W-1));

   logic [REG_W-1:0] en_q;
   logic [REG_W-1:0] pri_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= '0;
         pri_q <= '0;
      end else if (wr_en) begin
         if (sel) pri_q <= wdata & SRC_MASK;
         else     en_q  <= wdata & EN_MASK;
      end
   end

   assign rdata  = sel ? pri_q : en_q;
   assign glb_en = en_q[REG_W-1];
   assign src_en = en_q[NUM_SRC-1:0] & {NUM_SRC{glb_en}};
   assign src_hi = pri_q[NUM_SRC-1:0];

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int unsigned NUM_SRC   = 5,
   parameter int unsigned IDX_W     = 3,
   parameter bit          LOW_FIRST = 1'b1
) (
   input  logic [NUM_SRC-1:0] cand,
   output logic               hit,
   output logic [IDX_W-1:0]   idx
);

   assign hit = |cand;

   generate
      if (LOW_FIRST) begin : g_low_first
         always_comb begin
            idx = '0;
            for (int i = NUM_SRC - 1; i >= 0; i--)
               if (cand[i]) idx = IDX_W'(i);
         end
      end else begin : g_high_first
         always_comb begin
            idx = '0;
            for (int i = 0; i < NUM_SRC; i++)
               if (cand[i]) idx = IDX_W'(i);
         end
      end
   endgenerate

endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track
   import irq_arb_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  irq_lvl_e          take_lvl,
   input  logic              reti,
   output logic [LVL_N-1:0]  active
);

   logic [LVL_N-1:0] clr;
   logic [LVL_N-1:0] set;

   always_comb begin
      clr = '0;
      if (reti) begin
         if (active[LVL_HI]) clr[LVL_HI] = 1'b1;
         else                clr[LVL_LO] = 1'b1;
      end
      set = '0;
      if (take) set[take_lvl] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active <= '0;
      else        active <= (active & ~clr) | set;
   end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import irq_arb_pkg::*;
#(
   parameter int unsigned NUM_SRC    = 5,
   parameter int unsigned REG_W      = 8,
   parameter int unsigned VEC_W      = 16,
   parameter int unsigned VEC_BASE   = 3,
   parameter int unsigned VEC_STRIDE = 8,
   parameter bit          SAMPLE_REQ = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_wr_en,
   input  logic               cfg_sel,
   input  logic [REG_W-1:0]   cfg_wdata,
   output logic [REG_W-1:0]   cfg_rdata,
   input  logic [NUM_SRC-1:0] src_req,
   output logic               irq_valid,
   output logic               irq_level,
   output logic [VEC_W-1:0]   irq_vector,
   input  logic               irq_ack,
   input  logic               irq_reti,
   output logic [LVL_N-1:0]   active_lvl
);

   localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   generate
      if (NUM_SRC + 1 > REG_W) begin : g_bad_reg_w
         $error("register too narrow for sources plus master enable");
      end
      if (VEC_W < 32 && (VEC_BASE + (NUM_SRC - 1) * VEC_STRIDE) >= (1 << VEC_W)) begin : g_bad_vec_w
         $error("vector range exceeds vector width");
      end
   endgenerate

   logic [NUM_SRC-1:0] src_en;
   logic [NUM_SRC-1:0] src_hi;
   logic               glb_en;
   logic [NUM_SRC-1:0] req_q;

   irq_cfg_regs #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_wr_en),
      .sel    (cfg_sel),
      .wdata  (cfg_wdata),
      .rdata  (cfg_rdata),
      .src_en (src_en),
      .src_hi (src_hi),
      .glb_en (glb_en)
   );

   generate
      if (SAMPLE_REQ) begin : g_sample
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) req_q <= '0;
            else        req_q <= src_req;
         end
      end else begin : g_direct
         assign req_q = src_req;
      end
   endgenerate

   logic [NUM_SRC-1:0] cand;
   logic [NUM_SRC-1:0] cand_hi;
   logic [NUM_SRC-1:0] cand_lo;
   logic               hit_hi, hit_lo;
   logic [IDX_W-1:0]   idx_hi, idx_lo;

   assign cand    = req_q & src_en;
   assign cand_hi = cand & src_hi;
   assign cand_lo = cand & ~src_hi;

   irq_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .LOW_FIRST(1'b1)) u_pick_hi (
      .cand (cand_hi),
      .hit  (hit_hi),
      .idx  (idx_hi)
   );

   irq_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .LOW_FIRST(1'b1)) u_pick_lo (
      .cand (cand_lo),
      .hit  (hit_lo),
      .idx  (idx_lo)
   );

   logic             show_hi, show_lo;
   logic [IDX_W-1:0] win_idx;
   irq_lvl_e         win_lvl;

   assign show_hi = hit_hi && !active_lvl[LVL_HI];
   assign show_lo = hit_lo && !show_hi && (active_lvl == '0);
   assign win_lvl = show_hi ? LVL_HI : LVL_LO;
   assign win_idx = show_hi ? idx_hi : idx_lo;

   assign irq_valid  = show_hi || show_lo;
   assign irq_level  = irq_valid && (win_lvl == LVL_HI);
   assign irq_vector = irq_valid
                     ? VEC_W'(VEC_BASE) + VEC_W'(win_idx) * VEC_W'(VEC_STRIDE)
                     : '0;

   irq_svc_track u_svc (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (irq_valid && irq_ack),
      .take_lvl (win_lvl),
      .reti     (irq_reti),
      .active   (active_lvl)
   );

endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       irq_valid,
   input logic       irq_level,
   input logic       irq_ack,
   input logic       irq_reti,
   input logic [1:0] active_lvl,
   input logic       glb_en
);

   // R1
   reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (active_lvl == 2'b00));

   // R3
   glb_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en |-> !irq_valid);

   // R11
   hi_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active_lvl[1] |-> !irq_valid);

   // R11
   lo_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && active_lvl[0]) |-> irq_level);

   // R10
   ack_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && irq_ack && irq_level) |=> active_lvl[1]);

   // R10
   ack_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && irq_ack && !irq_level) |=> active_lvl[0]);

   // R12
   reti_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_reti && active_lvl[1]) |=> !active_lvl[1]);

endmodule

bind prio_irq_ctrl irq_arb_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .irq_valid  (irq_valid),
   .irq_level  (irq_level),
   .irq_ack    (irq_ack),
   .irq_reti   (irq_reti),
   .active_lvl (active_lvl),
   .glb_en     (glb_en)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic        cfg_sel = 1'b0;
   logic [7:0]  cfg_wdata = '0;
   logic [7:0]  cfg_rdata;
   logic [4:0]  src_req = '0;
   logic        irq_valid;
   logic        irq_level;
   logic [15:0] irq_vector;
   logic        irq_ack = 1'b0;
   logic        irq_reti = 1'b0;
   logic [1:0]  active_lvl;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   prio_irq_ctrl u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_wr_en  (cfg_wr_en),
      .cfg_sel    (cfg_sel),
      .cfg_wdata  (cfg_wdata),
      .cfg_rdata  (cfg_rdata),
      .src_req    (src_req),
      .irq_valid  (irq_valid),
      .irq_level  (irq_level),
      .irq_vector (irq_vector),
      .irq_ack    (irq_ack),
      .irq_reti   (irq_reti),
      .active_lvl (active_lvl)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] vec_of(input int idx);
      return 16'h0003 + 16'(idx * 8);
   endfunction

   task automatic wr_cfg(input logic sel, input logic [7:0] d);
      cfg_sel = sel; cfg_wdata = d; cfg_wr_en = 1'b1;
      step();
      cfg_wr_en = 1'b0;
   endtask

   task automatic rd_cfg(input logic sel, output logic [7:0] d);
      cfg_sel = sel;
      #0.5;
      d = cfg_rdata;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      repeat (3) step();
      chk("R1 valid in reset", irq_valid, 0);
      chk("R1 active in reset", active_lvl, 0);
      rst_n = 1'b1;
      step();
      rd_cfg(1'b0, d); chk("R1 enable reg", d, 8'h00);
      rd_cfg(1'b1, d); chk("R1 priority reg", d, 8'h00);
      chk("R1 active after reset", active_lvl, 0);
   endtask

   task automatic t_regs();
      logic [7:0] d;
      wr_cfg(1'b0, 8'hFF);
      rd_cfg(1'b0, d); chk("R2 reserved read zero", d, 8'h9F);
      wr_cfg(1'b1, 8'hFF);
      rd_cfg(1'b1, d); chk("R6 upper bits read zero", d, 8'h1F);
      wr_cfg(1'b1, 8'h00);
      wr_cfg(1'b0, 8'h00);
   endtask

   task automatic t_global();
      wr_cfg(1'b0, 8'h1F);
      src_req = 5'h1F;
      step();
      chk("R3 master off", irq_valid, 0);
      step();
      chk("R3 master off hold", irq_valid, 0);
      wr_cfg(1'b0, 8'h9F);
      chk("R3 master on valid", irq_valid, 1);
      chk("R7 all pending ext0 wins", irq_vector, vec_of(0));
      src_req = '0;
      step();
   endtask

   task automatic t_latency();
      src_req = 5'b00100;
      #1;
      chk("R5 not same cycle", irq_valid, 0);
      step();
      chk("R5 next edge valid", irq_valid, 1);
      chk("R9 ext1 vector", irq_vector, vec_of(2));
      src_req = '0;
      step();
      chk("R5 drop seen", irq_valid, 0);
   endtask

   task automatic t_enable();
      wr_cfg(1'b0, 8'h82);
      src_req = 5'h1D;
      step();
      chk("R4 disabled sources", irq_valid, 0);
      src_req = 5'h1F;
      step();
      chk("R4 only timer0", irq_vector, vec_of(1));
      wr_cfg(1'b0, 8'hE2);
      chk("R2 reserved bits no effect", irq_vector, vec_of(1));
      chk("R2 reserved valid", irq_valid, 1);
      wr_cfg(1'b0, 8'h9F);
      src_req = '0;
      step();
   endtask

   task automatic t_tiebreak();
      logic [4:0] pat [4] = '{5'b11000, 5'b10000, 5'b01010, 5'b10100};
      int         win [4] = '{3, 4, 1, 2};
      for (int k = 0; k < 4; k++) begin
         src_req = pat[k];
         step();
         chk("R7 tie order", irq_vector, vec_of(win[k]));
         chk("R9 level low", irq_level, 0);
      end
      src_req = '0;
      step();
   endtask

   task automatic t_priority();
      wr_cfg(1'b1, 8'h10);
      src_req = 5'h1F;
      step();
      chk("R8 serial high wins", irq_vector, vec_of(4));
      chk("R8 level high", irq_level, 1);
      wr_cfg(1'b1, 8'h0C);
      chk("R7 tie in high level", irq_vector, vec_of(2));
      src_req = '0;
      wr_cfg(1'b1, 8'h00);
   endtask

   task automatic t_nesting();
      wr_cfg(1'b1, 8'h08);
      src_req = 5'b00001;
      step();
      chk("R10 low shown", irq_vector, vec_of(0));
      irq_ack = 1'b1; step(); irq_ack = 1'b0;
      chk("R10 low in service", active_lvl, 2'b01);
      chk("R11 low blocks low", irq_valid, 0);
      src_req = 5'b00011;
      step();
      chk("R11 same level waits", irq_valid, 0);
      src_req = 5'b01011;
      step();
      chk("R11 high preempts", irq_vector, vec_of(3));
      chk("R11 high level", irq_level, 1);
      irq_ack = 1'b1; step(); irq_ack = 1'b0;
      chk("R10 both in service", active_lvl, 2'b11);
      chk("R11 high blocks all", irq_valid, 0);
      src_req = 5'b00011; irq_reti = 1'b1;
      step();
      irq_reti = 1'b0;
      chk("R12 return clears high", active_lvl, 2'b01);
      chk("R12 still blocked", irq_valid, 0);
      irq_reti = 1'b1; step(); irq_reti = 1'b0;
      chk("R12 return clears low", active_lvl, 2'b00);
      chk("R12 pending low shown", irq_vector, vec_of(0));
      src_req = '0;
      step();
   endtask

   task automatic t_collide();
      src_req = 5'b00010;
      step();
      irq_ack = 1'b1; step(); irq_ack = 1'b0;
      chk("R10 low taken", active_lvl, 2'b01);
      src_req = 5'b01000;
      step();
      chk("R12 high shown", irq_level, 1);
      irq_ack = 1'b1; irq_reti = 1'b1;
      step();
      irq_ack = 1'b0; irq_reti = 1'b0;
      chk("R12 ack and return same cycle", active_lvl, 2'b10);
      src_req = '0;
      irq_reti = 1'b1; step(); irq_reti = 1'b0;
      chk("R12 idle after return", active_lvl, 2'b00);
      irq_reti = 1'b1; step(); irq_reti = 1'b0;
      chk("R12 return with none active", active_lvl, 2'b00);
      wr_cfg(1'b1, 8'h00);
   endtask

   initial begin
      t_reset();
      t_regs();
      t_global();
      t_latency();
      t_enable();
      t_tiebreak();
      t_priority();
      t_nesting();
      t_collide();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule